// File: doc/BRIEF.md
# Keypad Matrix Scanner

This block scans a keypad wired as a matrix of row lines and column lines. During a scan it pulls one row line low at a time, holds it for a programmed number of clock cycles, and then stores the active-low column levels in a per-row data word. Software selects one of four operating modes. The block can stay idle, watch for any key while all rows are pulled low, scan the matrix once, or scan it over and over with a programmed pause between passes.

A small word-addressed register port holds the control and geometry settings, a three-bit event status with write-one-to-clear, a matching enable mask, and the stored key data, two rows per 32-bit word. A single interrupt line is raised while any enabled status bit is set.

Top module: `kpd_matrix_scanner`

## Requirements
- R1: After reset the control word reads 0, every stored row reads 16'hFFFF, all row outputs are high, status is 0 and the interrupt output is low.
- R2: The mode field is control bits 1:0 (0 idle, 1 any-key watch, 2 one pass, 3 repeating). After a one-pass scan finishes, the mode field reads back 0 without being written.
- R3: During a scan exactly one row output is low, and it stays low for (control bits 15:2) + 1 cycles. The column inputs are stored at the last of those cycles. Outside a scan and outside any-key mode, all row outputs are high.
- R4: In repeating mode, row 0 goes low again every N*(D+1) + G + 1 cycles. N is the scanned row count, D is the row delay and G is control bits 31:16.
- R5: Only rows below the row count (size bits 7:0, capped at the number of row lines) are stored. Other rows keep their contents. With a count of 0 a scan completes without storing anything.
- R6: Column bits at or above the column count (size bits 15:8) are stored as 1.
- R7: Status bit 0 is set when a scan completes. Writing 1 to a status bit clears it.
- R8: Status bit 1 is set when a stored row takes a value different from its previous one. It is not set when a scan stores identical values.
- R9: In any-key mode all row outputs are low and no row data is stored. Status bit 2 is set while any column reads low, and a clear of it has no effect until all keys are released.
- R10: The interrupt output is high exactly when some status bit and its mask bit (mask register bits 2:0) are both set.
- R11: Register word offsets are 0x00 control, 0x04 size, 0x08 status, 0x0C mask. Word 0x10 + 4k holds row 2k in bits 15:0 and row 2k+1 in bits 31:16.
- R12: Writing mode 0 during a scan stops it: all row outputs go high and no completion is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all delays count its cycles |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 6 | Byte address of the register word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| row_n_o | output | 16 | Active-low row drive |
| col_n_i | input | 16 | Active-low column sense |
| irq_o | output | 1 | Interrupt request, high while an enabled event is pending |

## Verification
A wrong row counter or a delay compare that is off by one is visible on row_n_o within one row period. The low pulse becomes longer or shorter than D+1 cycles, or a row is skipped, and a key placed on a known row then lands in the wrong data word. A sequencer that fails to return to idle shows up as the mode field staying non-zero, or as row lines still toggling after an abort. A status bit that clears too eagerly shows up on irq_o one cycle after the clearing write.

// File: rtl/kpd_pkg.sv
package kpd_pkg;
  // mode field codes (control bits 1:0)
  localparam logic [1:0] MODE_IDLE   = 2'd0;
  localparam logic [1:0] MODE_ANYKEY = 2'd1;
  localparam logic [1:0] MODE_ONCE   = 2'd2;
  localparam logic [1:0] MODE_LOOP   = 2'd3;

  // register word indices (byte address / 4)
  localparam int unsigned WI_CTRL = 0;
  localparam int unsigned WI_SIZE = 1;
  localparam int unsigned WI_STAT = 2;
  localparam int unsigned WI_MASK = 3;
  localparam int unsigned WI_DATA = 4;

  typedef enum logic [1:0] {SQ_IDLE, SQ_ROW, SQ_GAP} seq_state_e;
endpackage

// File: rtl/kpd_regs.sv
module kpd_regs
  import kpd_pkg::*;
#(
  parameter int unsigned NUM_ROWS = 16,
  parameter int unsigned NUM_COLS = 16,
  parameter int unsigned ADDR_W   = 6
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         bus_wr,
  input  logic [ADDR_W-1:0]            bus_addr,
  input  logic [31:0]                  bus_wdata,
  output logic [31:0]                  bus_rdata,
  input  logic [NUM_ROWS*NUM_COLS-1:0] row_data,
  input  logic                         scan_done,
  input  logic                         data_chg,
  input  logic                         key_hit,
  output logic [1:0]                   mode,
  output logic [13:0]                  row_dly,
  output logic [15:0]                  gap_dly,
  output logic [7:0]                   n_rows,
  output logic [7:0]                   n_cols,
  output logic                         irq_o
);
  localparam int unsigned WORD_W = ADDR_W - 2;
  localparam int unsigned PAIRS  = (NUM_ROWS + 1) / 2;

  logic [31:0] ctrl_q;
  logic [15:0] size_q;
  logic [2:0]  stat_q, mask_q;

  logic                aligned;
  logic [WORD_W-1:0]   word;
  logic                ctrl_wr, size_wr, stat_wr, mask_wr;
  logic [2:0]          stat_clr, stat_set;

  assign aligned = (bus_addr[1:0] == 2'b00);
  assign word    = bus_addr[ADDR_W-1:2];
  assign ctrl_wr = bus_wr && aligned && (word == WORD_W'(WI_CTRL));
  assign size_wr = bus_wr && aligned && (word == WORD_W'(WI_SIZE));
  assign stat_wr = bus_wr && aligned && (word == WORD_W'(WI_STAT));
  assign mask_wr = bus_wr && aligned && (word == WORD_W'(WI_MASK));

  assign stat_clr = stat_wr ? bus_wdata[2:0] : 3'b000;
  assign stat_set = {key_hit, data_chg, scan_done};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      size_q <= '0;
      stat_q <= '0;
      mask_q <= '0;
    end else begin
      if (ctrl_wr)
        ctrl_q <= bus_wdata;
      else if (scan_done && ctrl_q[1:0] == MODE_ONCE)
        ctrl_q[1:0] <= MODE_IDLE;
      if (size_wr) size_q <= bus_wdata[15:0];
      if (mask_wr) mask_q <= bus_wdata[2:0];
      // a pending event wins over a clear in the same cycle
      stat_q <= stat_set | (stat_q & ~stat_clr);
    end
  end

  assign mode    = ctrl_q[1:0];
  assign row_dly = ctrl_q[15:2];
  assign gap_dly = ctrl_q[31:16];
  assign n_rows  = size_q[7:0];
  assign n_cols  = size_q[15:8];
  assign irq_o   = |(stat_q & mask_q);

  always_comb begin
    bus_rdata = '0;
    if (aligned) begin
      if (word == WORD_W'(WI_CTRL)) bus_rdata = ctrl_q;
      if (word == WORD_W'(WI_SIZE)) bus_rdata = {16'h0, size_q};
      if (word == WORD_W'(WI_STAT)) bus_rdata = {29'h0, stat_q};
      if (word == WORD_W'(WI_MASK)) bus_rdata = {29'h0, mask_q};
      for (int p = 0; p < PAIRS; p++) begin
        if (word == WORD_W'(WI_DATA + p)) begin
          bus_rdata[NUM_COLS-1:0] = row_data[(2*p)*NUM_COLS +: NUM_COLS];
          if (2*p + 1 < NUM_ROWS)
            bus_rdata[16 +: NUM_COLS] = row_data[(2*p+1)*NUM_COLS +: NUM_COLS];
        end
      end
    end
  end

  // R2
  once_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_done && mode == MODE_ONCE && !ctrl_wr) |=> (mode == MODE_IDLE));
  // R7
  w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && bus_wdata[0] && !scan_done) |=> !stat_q[0]);
  // R9
  anykey_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    key_hit |=> stat_q[2]);
endmodule

// File: rtl/kpd_seq.sv
module kpd_seq
  import kpd_pkg::*;
#(
  parameter int unsigned NUM_ROWS = 16,
  parameter int unsigned NUM_COLS = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          mode,
  input  logic [13:0]         row_dly,
  input  logic [15:0]         gap_dly,
  input  logic [7:0]          n_rows,
  input  logic [NUM_COLS-1:0] col_n_i,
  output logic [NUM_ROWS-1:0] row_n_o,
  output logic                row_upd,
  output logic [7:0]          row_idx,
  output logic                scan_done,
  output logic                key_hit
);
  seq_state_e  st_q;
  logic [7:0]  row_q;
  logic [15:0] cnt_q;
  logic        run, anyk, dly_hit, gap_hit, last_row, empty;

  assign run      = mode[1];
  assign anyk     = (mode == MODE_ANYKEY);
  assign empty    = (n_rows == 8'd0);
  assign dly_hit  = (cnt_q == {2'b00, row_dly});
  assign gap_hit  = (cnt_q == gap_dly);
  assign last_row = ((row_q + 8'd1) >= n_rows);

  assign row_upd   = (st_q == SQ_ROW) && run && dly_hit;
  assign row_idx   = row_q;
  assign scan_done = (row_upd && last_row) || ((st_q == SQ_IDLE) && run && empty);
  assign key_hit   = anyk && !(&col_n_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SQ_IDLE;
      row_q <= '0;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        SQ_IDLE: begin
          cnt_q <= '0;
          row_q <= '0;
          if (run) st_q <= empty ? ((mode == MODE_LOOP) ? SQ_GAP : SQ_IDLE) : SQ_ROW;
        end
        SQ_ROW: begin
          if (!run) begin
            st_q <= SQ_IDLE;
          end else if (dly_hit) begin
            cnt_q <= '0;
            if (last_row) begin
              row_q <= '0;
              st_q  <= (mode == MODE_LOOP) ? SQ_GAP : SQ_IDLE;
            end else begin
              row_q <= row_q + 8'd1;
            end
          end else begin
            cnt_q <= cnt_q + 16'd1;
          end
        end
        SQ_GAP: begin
          if (!run) begin
            st_q <= SQ_IDLE;
          end else if (gap_hit) begin
            cnt_q <= '0;
            row_q <= '0;
            st_q  <= empty ? SQ_IDLE : SQ_ROW;
          end else begin
            cnt_q <= cnt_q + 16'd1;
          end
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
    assign row_n_o[r] = !(anyk || ((st_q == SQ_ROW) && run && (row_q == 8'(r))));
  end

  // R3
  row_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !anyk |-> $onehot0(~row_n_o));
  // R12
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_IDLE) |=> ((mode != MODE_IDLE) || (&row_n_o)));
endmodule

// File: rtl/kpd_rowstore.sv
module kpd_rowstore #(
  parameter int unsigned NUM_ROWS = 16,
  parameter int unsigned NUM_COLS = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         row_upd,
  input  logic [7:0]                   row_idx,
  input  logic [7:0]                   n_rows,
  input  logic [7:0]                   n_cols,
  input  logic [NUM_COLS-1:0]          col_n_i,
  output logic [NUM_ROWS*NUM_COLS-1:0] row_data,
  output logic                         data_chg
);
  // columns at or above the programmed count read as released
  function automatic logic [NUM_COLS-1:0] pad_cols(input logic [NUM_COLS-1:0] smp,
                                                   input logic [7:0] cnt);
    logic [NUM_COLS-1:0] v;
    for (int c = 0; c < NUM_COLS; c++)
      v[c] = (c >= int'(cnt)) ? 1'b1 : smp[c];
    return v;
  endfunction

  logic [NUM_COLS-1:0] fresh;
  logic [NUM_ROWS-1:0] hit, differ;

  assign fresh = pad_cols(col_n_i, n_cols);

  for (genvar r = 0; r < NUM_ROWS; r++) begin : g_store
    logic [NUM_COLS-1:0] data_q;
    assign hit[r]    = row_upd && (row_idx == 8'(r));
    assign differ[r] = hit[r] && (fresh != data_q);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      data_q <= '1;
      else if (hit[r]) data_q <= fresh;
    end
    assign row_data[r*NUM_COLS +: NUM_COLS] = data_q;
  end

  assign data_chg = |differ;

  // R5
  rows_beyond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    row_upd |-> (row_idx < n_rows));
  // R8
  same_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !data_chg |=> $stable(row_data));
endmodule

// File: rtl/kpd_matrix_scanner.sv
module kpd_matrix_scanner #(
  parameter int unsigned NUM_ROWS = 16,
  parameter int unsigned NUM_COLS = 16,
  parameter int unsigned ADDR_W   = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  output logic [NUM_ROWS-1:0] row_n_o,
  input  logic [NUM_COLS-1:0] col_n_i,
  output logic                irq_o
);
  localparam logic [7:0] ROW_CAP = 8'(NUM_ROWS);

  logic [1:0]                   mode;
  logic [13:0]                  row_dly;
  logic [15:0]                  gap_dly;
  logic [7:0]                   n_rows_raw, n_rows_eff, n_cols;
  logic                         row_upd, scan_done, key_hit, data_chg;
  logic [7:0]                   row_idx;
  logic [NUM_ROWS*NUM_COLS-1:0] row_data;

  assign n_rows_eff = (n_rows_raw > ROW_CAP) ? ROW_CAP : n_rows_raw;

  kpd_regs #(.NUM_ROWS(NUM_ROWS), .NUM_COLS(NUM_COLS), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .row_data(row_data),
    .scan_done(scan_done), .data_chg(data_chg), .key_hit(key_hit),
    .mode(mode), .row_dly(row_dly), .gap_dly(gap_dly),
    .n_rows(n_rows_raw), .n_cols(n_cols), .irq_o(irq_o)
  );

  kpd_seq #(.NUM_ROWS(NUM_ROWS), .NUM_COLS(NUM_COLS)) u_seq (
    .clk(clk), .rst_n(rst_n), .mode(mode), .row_dly(row_dly), .gap_dly(gap_dly),
    .n_rows(n_rows_eff), .col_n_i(col_n_i), .row_n_o(row_n_o),
    .row_upd(row_upd), .row_idx(row_idx), .scan_done(scan_done), .key_hit(key_hit)
  );

  kpd_rowstore #(.NUM_ROWS(NUM_ROWS), .NUM_COLS(NUM_COLS)) u_store (
    .clk(clk), .rst_n(rst_n), .row_upd(row_upd), .row_idx(row_idx),
    .n_rows(n_rows_eff), .n_cols(n_cols), .col_n_i(col_n_i),
    .row_data(row_data), .data_chg(data_chg)
  );
endmodule

// File: tb/tb_kpd_matrix_scanner.sv
module tb_kpd_matrix_scanner;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_wr = 0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] row_n, col_n;
  logic        irq;

  int checks = 0;
  int errors = 0;

  logic [15:0] keys    [16];
  logic [15:0] exp_row [16];

  always #2 clk = ~clk;

  kpd_matrix_scanner dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .row_n_o(row_n),
    .col_n_i(col_n), .irq_o(irq)
  );

  // keypad model: a pressed key connects its row line to its column line
  always_comb begin
    col_n = '1;
    for (int r = 0; r < 16; r++)
      for (int c = 0; c < 16; c++)
        if (keys[r][c] && !row_n[r]) col_n[c] = 1'b0;
  end

  // vector: {rows[7:0], cols[7:0], key_row[3:0], key_col[3:0], row_delay[7:0]}
  localparam logic [31:0] VEC [6] = '{
    {8'd16, 8'd16, 4'd0,  4'd0,  8'd0},
    {8'd16, 8'd16, 4'd15, 4'd15, 8'd3},
    {8'd4,  8'd16, 4'd5,  4'd2,  8'd1},
    {8'd16, 8'd8,  4'd3,  4'd10, 8'd2},
    {8'd8,  8'd4,  4'd7,  4'd3,  8'd0},
    {8'd20, 8'd20, 4'd9,  4'd6,  8'd1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  function automatic logic [31:0] ctrl_word(input int gap, input int dly, input int md);
    return {16'(gap), 14'(dly), 2'(md)};
  endfunction

  // expected contents after one scan, written from the requirements
  task automatic model_scan(input int nr, input int nc);
    for (int r = 0; r < 16; r++) begin
      if (r < nr) begin
        logic [15:0] v = 16'hFFFF;
        for (int c = 0; c < 16; c++)
          if (c < nc && keys[r][c]) v[c] = 1'b0;
        exp_row[r] = v;
      end
    end
  endtask

  task automatic press_only(input int r, input int c);
    for (int i = 0; i < 16; i++) keys[i] = '0;
    keys[r][c] = 1'b1;
  endtask

  task automatic wait_done(input string req);
    logic [31:0] d;
    bit seen = 0;
    for (int i = 0; i < 5000 && !seen; i++) begin
      rd(6'h08, d);
      if (d[0]) seen = 1;
      else @(negedge clk);
    end
    chk(req, 32'(seen), 32'd1);
    wr(6'h08, 32'h1);
  endtask

  task automatic check_words(input string req);
    logic [31:0] d;
    for (int k = 0; k < 8; k++) begin
      rd(6'(6'h10 + 4*k), d);
      chk(req, d, {exp_row[2*k+1], exp_row[2*k]});
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int n;
    for (int i = 0; i < 16; i++) begin keys[i] = '0; exp_row[i] = 16'hFFFF; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    rd(6'h00, d); chk("R1 ctrl", d, 32'h0);
    rd(6'h08, d); chk("R1 status", d, 32'h0);
    rd(6'h10, d); chk("R1 data", d, 32'hFFFF_FFFF);
    chk("R1 rows", 32'(row_n), 32'h0000_FFFF);
    chk("R1 irq", 32'(irq), 32'h0);

    // table walk: R11 layout, R5 row limit, R6 column padding
    for (int v = 0; v < 6; v++) begin
      press_only(int'(VEC[v][15:12]), int'(VEC[v][11:8]));
      wr(6'h04, {16'h0, VEC[v][23:16], VEC[v][31:24]});
      wr(6'h00, ctrl_word(0, int'(VEC[v][7:0]), 2));
      wait_done("R7 scan complete");
      model_scan(int'(VEC[v][31:24]), int'(VEC[v][23:16]));
      check_words("R5 R6 R11 data");
      rd(6'h00, d); chk("R2 mode back to idle", 32'(d[1:0]), 32'h0);
    end

    // R8 identical rescan sets no change flag; a new key does
    wr(6'h08, 32'h2);
    wr(6'h00, ctrl_word(0, 1, 2));
    wait_done("R7 rescan");
    rd(6'h08, d); chk("R8 no change", 32'(d[1]), 32'h0);
    press_only(1, 1);
    wr(6'h00, ctrl_word(0, 1, 2));
    wait_done("R7 rescan2");
    rd(6'h08, d); chk("R8 change", 32'(d[1]), 32'h1);
    model_scan(16, 16);

    // R5 zero rows: completes, stores nothing
    press_only(4, 4);
    wr(6'h04, 32'h0000_1000);
    wr(6'h00, ctrl_word(0, 0, 2));
    wait_done("R5 zero rows done");
    check_words("R5 zero rows data");

    // R3 row pulse width and single active row
    wr(6'h04, 32'h0000_1010);
    wr(6'h00, ctrl_word(0, 5, 2));
    while (row_n[0] !== 1'b0) @(negedge clk);
    chk("R3 one row low", 32'($countones(~row_n)), 32'd1);
    n = 0;
    while (row_n[0] === 1'b0) begin n++; @(negedge clk); end
    chk("R3 row width", 32'(n), 32'd6);
    wait_done("R3 done");
    model_scan(16, 16);
    chk("R3 rows released", 32'(row_n), 32'h0000_FFFF);

    // R4 repeating period: 2*(1+1) + 3 + 1 = 8
    wr(6'h04, 32'h0000_1002);
    wr(6'h00, ctrl_word(3, 1, 3));
    while (row_n[0] !== 1'b0) @(negedge clk);
    n = 0;
    while (row_n[0] === 1'b0) begin n++; @(negedge clk); end
    while (row_n[0] === 1'b1) begin n++; @(negedge clk); end
    chk("R4 period", 32'(n), 32'd8);
    wr(6'h00, 32'h0);
    @(negedge clk);
    chk("R12 released after stop", 32'(row_n), 32'h0000_FFFF);

    // R12 abort a long one-pass scan
    wr(6'h04, 32'h0000_1010);
    wr(6'h08, 32'h7);
    wr(6'h00, ctrl_word(0, 100, 2));
    repeat (20) @(negedge clk);
    wr(6'h00, 32'h0);
    repeat (300) @(negedge clk);
    rd(6'h08, d); chk("R12 no completion", 32'(d[0]), 32'h0);
    chk("R12 rows high", 32'(row_n), 32'h0000_FFFF);

    // R9 any-key watch
    press_only(2, 2);
    wr(6'h00, ctrl_word(0, 0, 1));
    chk("R9 all rows low", 32'(row_n), 32'h0);
    @(negedge clk);
    rd(6'h08, d); chk("R9 key flag", 32'(d[2]), 32'h1);
    wr(6'h08, 32'h4);
    rd(6'h08, d); chk("R9 held while pressed", 32'(d[2]), 32'h1);
    check_words("R9 no data update");
    keys[2] = '0;
    repeat (2) @(negedge clk);
    wr(6'h08, 32'h4);
    rd(6'h08, d); chk("R9 clears after release", 32'(d[2]), 32'h0);
    wr(6'h00, 32'h0);

    // R10 interrupt masking
    wr(6'h08, 32'h7);
    wr(6'h0C, 32'h0);
    wr(6'h04, 32'h0000_1001);
    wr(6'h00, ctrl_word(0, 0, 2));
    repeat (10) @(negedge clk);
    chk("R10 masked", 32'(irq), 32'h0);
    wr(6'h0C, 32'h1);
    chk("R10 enabled", 32'(irq), 32'h1);
    wr(6'h08, 32'h1);
    chk("R10 cleared", 32'(irq), 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule